// File: doc/BRIEF.md
# Write-Once Watchdog Timer with Debug Freeze

This block is a watchdog for a processor subsystem. A fixed prescaler divides the input clock by 4096 and drives a 16-bit down-counter. Software keeps the system alive by pulsing `service`. Each pulse reloads the counter from the modulus register. If software stops servicing, the counter passes zero and wraps to all ones. That wrap raises `fault`, and `fault` stays high until the asynchronous hardware reset.

Software reaches three registers through a single-cycle 24-bit register port: a control word, the 16-bit modulus and the read-only live count. Outside debug, the control and modulus registers are write-once, which guards against runaway code that would otherwise rewrite them. While `debug_mode` is high, both registers can be rewritten without limit, and those writes do not spend the single normal-mode write. Also while in debug, the stop bit of the control word freezes the timer or lets it run. When debug ends, the timer continues from the state it was frozen in.

Top module: `wdog_timer`

## Requirements
- R1: After hardware reset, the count reads 0x00FFFF, the control register reads 0x00000F, the modulus reads 0x00FFFF and `fault` is low.
- R2: While the timer runs, the count decreases by exactly one on every 4096th running clock. Every reload restarts this 4096-cycle period from zero.
- R3: On a decrement that takes the count from 0x0000 to 0xFFFF, `fault` goes high on that same edge. It then stays high until `rst_n` goes low.
- R4: A cycle with `service` high loads the current modulus into the count at the next edge.
- R5: An accepted modulus write puts the written low 16 bits into the count at the same edge. All later service reloads use that value. If `service` is high in the same cycle, the written value wins.
- R6: With `debug_mode` low, the control and modulus registers each take only their first write after reset. Later normal-mode writes to that register change nothing, and an ignored modulus write does not reload the count.
- R7: With `debug_mode` high, the control and modulus registers accept every write. The written values remain after `debug_mode` falls.
- R8: A write made with `debug_mode` high does not spend the single normal-mode write. A register that has received only debug writes still accepts one write after debug ends.
- R9: Select code 0 is control, 1 is modulus and 2 is count. The read data follows `reg_sel` in the same cycle. Writes to select 2 or 3 change nothing. Select 3 reads zero, and bits 23 to 16 of the modulus and count reads are zero.
- R10: Control bit 3 is the stop bit. With `debug_mode` high and bit 3 set, both the count and the prescaler hold their values. With bit 3 clear, or with `debug_mode` low, the timer runs. Counting resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the prescaler and all registers |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| debug_mode | input | 1 | High while the system is in debug; lifts the write-once rule and enables the stop bit |
| reg_sel | input | 2 | Register select: 0 control, 1 modulus, 2 count |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data of the selected register, combinational |
| service | input | 1 | Service strobe; reloads the count from the modulus |
| fault | output | 1 | Sticky underflow indication, cleared only by reset |

## Verification
A wrong lock state shows at the next read of the control or modulus register, because that read returns a stale or overwritten value. A wrong modulus write can also show through the count, which jumps when it should not, or fails to jump when it should. A prescaler that is off by even one cycle moves the count on the wrong edge. That error is visible only 4096 cycles after a reload, so the bench compares the live count on every cycle. A stop bit that is ignored, or applied outside debug, shows as a count that moves during a freeze or sits still outside one. The same check exposes a wrong stop-bit state within one prescale period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_MOD   = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_NONE  = 2'd3
   } wd_sel_e;
endpackage

// File: rtl/wdog_lock_reg.sv
module wdog_lock_reg #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dbg,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q,
   output logic         locked,
   output logic         accept
);
   // debug writes always land and never consume the single normal write
   assign accept = wr && (dbg || !locked);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= RST_VAL;
         locked <= 1'b0;
      end else begin
         if (accept) q <= wdata;
         if (wr && !dbg) locked <= 1'b1;
      end
   end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned PRE_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic tick
);
   generate
      if (PRE_W == 0) begin : g_direct
         assign tick = run && !clear;
      end else begin : g_div
         logic [PRE_W-1:0] pre_q;
         assign tick = run && !clear && (&pre_q);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pre_q <= '0;
            else if (clear) pre_q <= '0;
            else if (run)   pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] count,
   output logic         fault
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '1;
         fault <= 1'b0;
      end else if (load) begin
         count <= load_val;
      end else if (dec) begin
         count <= count - 1'b1;
         if (count == '0) fault <= 1'b1;
      end
   end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
   parameter int unsigned BUS_W    = 24,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRE_W    = 12,
   parameter int unsigned STOP_BIT = 3,
   parameter logic [BUS_W-1:0] CTRL_RST = 24'h00000F,
   parameter logic [CNT_W-1:0] MOD_RST  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             debug_mode,
   input  logic [1:0]       reg_sel,
   input  logic             reg_wr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   input  logic             service,
   output logic             fault
);
   import wdog_pkg::*;

   localparam int unsigned PAD_W = BUS_W - CNT_W;

   if (CNT_W > BUS_W) begin : g_bad_cnt_w
      $error("CNT_W must not exceed BUS_W");
   end
   if (STOP_BIT >= BUS_W) begin : g_bad_stop
      $error("STOP_BIT must lie inside the control word");
   end
   if (PRE_W > 24) begin : g_bad_pre
      $error("PRE_W out of range");
   end

   wd_sel_e sel;
   assign sel = wd_sel_e'(reg_sel);

   logic [BUS_W-1:0] ctrl_q;
   logic [CNT_W-1:0] mod_q, count_q;
   logic ctrl_locked, mod_locked, ctrl_acc, mod_acc;
   logic run, reload, tick;
   logic [CNT_W-1:0] load_val;

   wdog_lock_reg #(.W(BUS_W), .RST_VAL(CTRL_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .dbg(debug_mode),
      .wr(reg_wr && sel == SEL_CTRL), .wdata(reg_wdata),
      .q(ctrl_q), .locked(ctrl_locked), .accept(ctrl_acc));

   wdog_lock_reg #(.W(CNT_W), .RST_VAL(MOD_RST)) u_mod (
      .clk(clk), .rst_n(rst_n), .dbg(debug_mode),
      .wr(reg_wr && sel == SEL_MOD), .wdata(reg_wdata[CNT_W-1:0]),
      .q(mod_q), .locked(mod_locked), .accept(mod_acc));

   // stop bit only has meaning while debug is active
   assign run      = !(debug_mode && ctrl_q[STOP_BIT]);
   assign reload   = service || mod_acc;
   assign load_val = mod_acc ? reg_wdata[CNT_W-1:0] : mod_q;

   wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .clear(reload), .tick(tick));

   wdog_down_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(reload), .load_val(load_val),
      .dec(tick), .count(count_q), .fault(fault));

   generate
      if (PAD_W == 0) begin : g_nopad
         always_comb begin
            unique case (sel)
               SEL_CTRL:  reg_rdata = ctrl_q;
               SEL_MOD:   reg_rdata = mod_q;
               SEL_COUNT: reg_rdata = count_q;
               default:   reg_rdata = '0;
            endcase
         end
      end else begin : g_pad
         always_comb begin
            unique case (sel)
               SEL_CTRL:  reg_rdata = ctrl_q;
               SEL_MOD:   reg_rdata = {{PAD_W{1'b0}}, mod_q};
               SEL_COUNT: reg_rdata = {{PAD_W{1'b0}}, count_q};
               default:   reg_rdata = '0;
            endcase
         end
      end
   endgenerate

   logic unused_acc;
   assign unused_acc = ctrl_acc ^ ctrl_locked;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int unsigned BUS_W    = 24,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned STOP_BIT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             debug_mode,
   input logic [1:0]       reg_sel,
   input logic             reg_wr,
   input logic [BUS_W-1:0] reg_rdata,
   input logic             service,
   input logic             fault,
   input logic [BUS_W-1:0] ctrl_q,
   input logic [CNT_W-1:0] mod_q,
   input logic [CNT_W-1:0] count_q,
   input logic             mod_locked,
   input logic             ctrl_locked
);
   logic mod_wr, ctrl_wr;
   assign mod_wr  = reg_wr && reg_sel == 2'd1;
   assign ctrl_wr = reg_wr && reg_sel == 2'd0;

   assert_fault_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   assert_service_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (service && !mod_wr) |=> count_q == $past(mod_q));

   assert_mod_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_wr && !debug_mode && mod_locked) |=> mod_q == $past(mod_q));

   assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !debug_mode && ctrl_locked) |=> ctrl_q == $past(ctrl_q));

   assert_step_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!service && !mod_wr) |=>
         (count_q == $past(count_q) || count_q == $past(count_q) - 1'b1));

   assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (debug_mode && ctrl_q[STOP_BIT] && !service && !mod_wr) |=>
         count_q == $past(count_q));

   assert_read_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel != 2'd0) |-> reg_rdata[BUS_W-1:CNT_W] == '0);
endmodule

bind wdog_timer wdog_timer_chk #(.BUS_W(BUS_W), .CNT_W(CNT_W), .STOP_BIT(STOP_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .debug_mode(debug_mode), .reg_sel(reg_sel),
   .reg_wr(reg_wr), .reg_rdata(reg_rdata), .service(service), .fault(fault),
   .ctrl_q(ctrl_q), .mod_q(mod_q), .count_q(count_q),
   .mod_locked(mod_locked), .ctrl_locked(ctrl_locked));

// File: tb/wdog_timer_test.sv
`timescale 1ns/100ps
module wdog_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        debug_mode = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        reg_wr = 1'b0;
   logic [23:0] reg_wdata = '0;
   logic [23:0] reg_rdata;
   logic        service = 1'b0;
   logic        fault;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state kept from the requirements
   logic [23:0] m_ctrl;
   logic [15:0] m_mod, m_cnt;
   int          m_pre;
   logic        m_fault, m_lk_ctrl, m_lk_mod;

   always #2 clk = ~clk;

   wdog_timer uut (
      .clk(clk), .rst_n(rst_n), .debug_mode(debug_mode), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .service(service), .fault(fault));

   function automatic logic [23:0] exp_rd(input logic [1:0] s);
      case (s)
         2'd0:    return m_ctrl;
         2'd1:    return {8'h00, m_mod};
         2'd2:    return {8'h00, m_cnt};
         default: return 24'h0;
      endcase
   endfunction

   task automatic model_reset();
      m_ctrl = 24'h00000F; m_mod = 16'hFFFF; m_cnt = 16'hFFFF;
      m_pre = 0; m_fault = 1'b0; m_lk_ctrl = 1'b0; m_lk_mod = 1'b0;
   endtask

   task automatic model_edge(input bit dbg, input bit we, input logic [1:0] s,
                             input logic [23:0] wd, input bit svc);
      bit run, macc, cacc, load;
      logic [15:0] lv;
      run  = !(dbg && m_ctrl[3]);
      cacc = we && s == 2'd0 && (dbg || !m_lk_ctrl);
      macc = we && s == 2'd1 && (dbg || !m_lk_mod);
      load = svc || macc;
      lv   = macc ? wd[15:0] : m_mod;
      if (we && !dbg && s == 2'd0) m_lk_ctrl = 1'b1;
      if (we && !dbg && s == 2'd1) m_lk_mod = 1'b1;
      if (cacc) m_ctrl = wd;
      if (macc) m_mod = wd[15:0];
      if (load) begin
         m_cnt = lv; m_pre = 0;
      end else if (run) begin
         if (m_pre == 4095) begin
            m_pre = 0;
            if (m_cnt == 16'h0) m_fault = 1'b1;
            m_cnt = m_cnt - 16'd1;
         end else m_pre = m_pre + 1;
      end
   endtask

   // one clock: drive, compare selected read and fault before the edge, advance model
   task automatic step(input bit dbg, input bit we, input logic [1:0] s,
                       input logic [23:0] wd, input bit svc, input string tag);
      @(negedge clk);
      debug_mode = dbg; reg_wr = we; reg_sel = s; reg_wdata = wd; service = svc;
      #1;
      n_cmp++;
      if (reg_rdata !== exp_rd(s)) begin
         n_bad++;
         $display("FAIL %s: sel=%0d rdata=%h expected %h", tag, s, reg_rdata, exp_rd(s));
      end
      n_cmp++;
      if (fault !== m_fault) begin
         n_bad++;
         $display("FAIL %s: fault=%b expected %b", tag, fault, m_fault);
      end
      @(posedge clk);
      model_edge(dbg, we, s, wd, svc);
   endtask

   task automatic idle(input int n, input bit dbg, input logic [1:0] s, input string tag);
      for (int i = 0; i < n; i++) step(dbg, 1'b0, s, 24'h0, 1'b0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_wr = 1'b0; service = 1'b0; debug_mode = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd24681));
      model_reset();
      do_reset();
      // R1 reset state
      step(0, 0, 2'd0, 0, 0, "R1");
      step(0, 0, 2'd1, 0, 0, "R1");
      step(0, 0, 2'd2, 0, 0, "R1");
      // R6 normal-mode write-once
      step(0, 1, 2'd0, 24'h000A05, 0, "R6");
      step(0, 0, 2'd0, 0, 0, "R6");
      step(0, 1, 2'd0, 24'h123456, 0, "R6");
      step(0, 0, 2'd0, 0, 0, "R6");
      // R5 modulus write loads count
      step(0, 1, 2'd1, 24'h000010, 0, "R5");
      step(0, 0, 2'd2, 0, 0, "R5");
      step(0, 1, 2'd1, 24'h000020, 0, "R6");
      step(0, 0, 2'd1, 0, 0, "R6");
      step(0, 0, 2'd2, 0, 0, "R6");
      // R9 count is read-only, select 3 reads zero
      step(0, 1, 2'd2, 24'hFF1234, 0, "R9");
      step(0, 1, 2'd3, 24'hFFFFFF, 0, "R9");
      step(0, 0, 2'd3, 0, 0, "R9");
      idle(4200, 0, 2'd2, "R2");
      // R4 service reload
      step(0, 0, 2'd2, 0, 1, "R4");
      step(0, 0, 2'd2, 0, 0, "R4");
      // R7/R8 debug writes
      do_reset();
      step(1, 1, 2'd1, 24'h000003, 0, "R7");
      step(1, 1, 2'd1, 24'h000300, 0, "R7");
      step(1, 1, 2'd0, 24'h000000, 0, "R7");
      step(0, 0, 2'd1, 0, 0, "R7");
      step(0, 1, 2'd1, 24'h000100, 0, "R8");
      step(0, 0, 2'd1, 0, 0, "R8");
      step(0, 1, 2'd0, 24'h000008, 0, "R8");
      step(0, 0, 2'd0, 0, 0, "R8");
      step(0, 1, 2'd0, 24'h000000, 0, "R6");
      step(0, 0, 2'd0, 0, 0, "R6");
      // R10 stop bit 3 freezes only in debug, resume from held state
      idle(2000, 0, 2'd2, "R10");
      idle(5000, 1, 2'd2, "R10");
      step(1, 1, 2'd0, 24'h000000, 0, "R10");
      idle(2500, 1, 2'd2, "R10");
      step(1, 1, 2'd0, 24'h000008, 0, "R10");
      idle(1000, 1, 2'd2, "R10");
      idle(3000, 0, 2'd2, "R10");
      // R3 underflow fault, sticky
      step(1, 1, 2'd1, 24'h000001, 0, "R3");
      idle(2 * 4096 + 20, 0, 2'd2, "R3");
      step(0, 0, 2'd2, 0, 1, "R3");
      idle(50, 0, 2'd2, "R3");
      do_reset();
      step(0, 0, 2'd2, 0, 0, "R3");
      // random mix
      for (int i = 0; i < 30000; i++) begin
         bit dbg, we, svc;
         logic [1:0] s;
         logic [23:0] wd;
         dbg = ($urandom % 4) == 0;
         we  = ($urandom % 12) == 0;
         svc = ($urandom % 40) == 0;
         s   = 2'($urandom % 4);
         wd  = 24'($urandom);
         if ($urandom % 2 == 0) wd = {20'h0, 4'($urandom)};
         if (i == 15000) do_reset();
         step(dbg, we, s, wd, svc, "R9");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule